// File: doc/BRIEF.md
# SIMD Floating-Point Compare Unit

This block is one registered pipeline stage that compares two 128-bit vectors of IEEE-754 values under an immediate-selected predicate. Every active lane becomes an all-ones mask when the predicate holds and an all-zeros mask when it does not. The datapath handles single-precision (32-bit) lanes and double-precision (64-bit) lanes, in either packed or scalar form. In scalar form only the lowest lane is compared. The bits of the result above that lane are copied unchanged from the first source.

The unit reads the current floating-point control/status word. It returns that word with the invalid-operation and denormal flags ORed in. It also reports whether a newly raised flag is unmasked, and in that case it withholds the destination write enable. A decode stage feeds it one operation per valid cycle, and the writeback stage uses the registered result one cycle later.

Top module: `simd_fcmp_unit`

## Requirements
- R1: The predicate is `imm[2:0]`. For predicates 0 to 7, the results as (unordered, equal, less, greater) bits are 0100, 0010, 0110, 1000, 1011, 1101, 1001 and 0111 respectively.
- R2: Bits 7:3 of `imm` have no effect on the result, the status word or the exception output.
- R3: When either operand of an active lane is a signalling NaN (exponent all ones, fraction non-zero, fraction MSB 0), that lane takes the predicate's unordered value and the invalid flag is raised.
- R4: When either operand is a quiet NaN (fraction MSB 1) and neither operand is a signalling NaN, the lane takes the unordered value. The invalid flag is raised only for predicates 1, 2, 5 and 6.
- R5: `mode` 0 compares four 32-bit lanes and `mode` 1 compares two 64-bit lanes. Each lane of `result` is either all ones (predicate true) or all zeros.
- R6: `mode` 2 compares bits 31:0 and copies `src_a[127:32]` into the result. `mode` 3 compares bits 63:0 and copies `src_a[127:64]` into the result.
- R7: For non-NaN operands, the order is signed numeric order, and +0 equals −0.
- R8: When the DAZ control bit (bit 6) is clear, a denormal operand in a non-NaN comparison raises the denormal flag. When DAZ is set, a denormal is compared as a zero of its own sign and raises no flag.
- R9: `csr_out` equals `csr_in` with the invalid flag (bit 0) and the denormal flag (bit 1) ORed in. All other bits pass through, and a flag that is already set stays set.
- R10: `xcpt_pending` is high when a newly raised invalid flag has mask bit 7 clear, or when a newly raised denormal flag has mask bit 8 clear. `wr_en` is `out_valid` with `xcpt_pending` low.
- R11: Outputs are registered. `out_valid` follows `in_valid` by one cycle, and reset clears `out_valid`, `result`, `xcpt_pending` and `wr_en`.
- R12: In packed modes the flags are the OR over all lanes. In scalar modes, lanes above the compared one raise no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| imm | input | 8 | Immediate; bits 2:0 select the predicate |
| mode | input | 2 | 0 packed single, 1 packed double, 2 scalar single, 3 scalar double |
| csr_in | input | 32 | Current control/status word |
| out_valid | output | 1 | Registered result valid |
| result | output | 128 | Lane masks and pass-through bits |
| csr_out | output | 32 | Status word with sticky flags merged |
| xcpt_pending | output | 1 | Unmasked flag raised by this operation |
| wr_en | output | 1 | Destination write enable |

## Verification
The assertions assume that `in_valid` is held low throughout reset. They also assume that `mode` and `src_a` are stable and meaningful in any cycle where `in_valid` is high. The scalar pass-through and lane-mask checks depend on that.

The bench drives every input on the falling clock edge and raises `in_valid` for exactly one cycle per operation. It samples the outputs on the next falling edge, which keeps each operation isolated from the one before. The operands are hand-chosen encodings, so the NaN class, the denormal status and the sign of every lane are known in advance.

// File: rtl/simd_fcmp_pkg.sv
package simd_fcmp_pkg;

   typedef enum logic [1:0] {
      CMP_PS = 2'd0,
      CMP_PD = 2'd1,
      CMP_SS = 2'd2,
      CMP_SD = 2'd3
   } cmp_mode_e;

   localparam int PRED_W = 3;

   // Per-lane classification handed from the lane comparator to predicate logic
   typedef struct packed {
      logic any_snan;
      logic any_qnan;
      logic denorm;
      logic eq;
      logic lt;
   } lane_cls_t;

   // Outcome row: {unordered, equal, less, greater}
   function automatic logic [3:0] pred_row(input logic [PRED_W-1:0] p);
      case (p)
         3'd0:    return 4'b0100;
         3'd1:    return 4'b0010;
         3'd2:    return 4'b0110;
         3'd3:    return 4'b1000;
         3'd4:    return 4'b1011;
         3'd5:    return 4'b1101;
         3'd6:    return 4'b1001;
         default: return 4'b0111;
      endcase
   endfunction

   function automatic logic pred_qnan_signals(input logic [PRED_W-1:0] p);
      return (p == 3'd1) || (p == 3'd2) || (p == 3'd5) || (p == 3'd6);
   endfunction

   function automatic logic pred_eval(input logic [PRED_W-1:0] p, input lane_cls_t c);
      logic [3:0] row;
      row = pred_row(p);
      if (c.any_snan || c.any_qnan) return row[3];
      else if (c.eq)                return row[2];
      else if (c.lt)                return row[1];
      else                          return row[0];
   endfunction

   function automatic logic pred_invalid(input logic [PRED_W-1:0] p, input lane_cls_t c);
      return c.any_snan || (c.any_qnan && pred_qnan_signals(p));
   endfunction

endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
   import simd_fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   input  logic                 daz,
   output lane_cls_t            cls
);
   localparam int W     = 1 + EXP_W + MAN_W;
   localparam int MAG_W = W - 1;

   if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
      $error("fcmp_lane: exponent and fraction need at least two bits");
   end

   logic [EXP_W-1:0] exp_a, exp_b;
   logic [MAN_W-1:0] man_a, man_b;
   logic             sgn_a, sgn_b;
   logic             nan_a, nan_b, sub_a, sub_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             both_zero, any_nan;

   always_comb begin
      sgn_a = op_a[W-1];
      sgn_b = op_b[W-1];
      exp_a = op_a[W-2:MAN_W];
      exp_b = op_b[W-2:MAN_W];
      man_a = op_a[MAN_W-1:0];
      man_b = op_b[MAN_W-1:0];

      nan_a = (&exp_a) && (|man_a);
      nan_b = (&exp_b) && (|man_b);
      sub_a = (~|exp_a) && (|man_a);
      sub_b = (~|exp_b) && (|man_b);

      mag_a = (daz && sub_a) ? '0 : op_a[MAG_W-1:0];
      mag_b = (daz && sub_b) ? '0 : op_b[MAG_W-1:0];

      any_nan      = nan_a || nan_b;
      cls.any_snan = (nan_a && !man_a[MAN_W-1]) || (nan_b && !man_b[MAN_W-1]);
      cls.any_qnan = (nan_a && man_a[MAN_W-1]) || (nan_b && man_b[MAN_W-1]);
      cls.denorm   = !any_nan && !daz && (sub_a || sub_b);

      both_zero = (mag_a == '0) && (mag_b == '0);
      cls.eq    = both_zero || ((sgn_a == sgn_b) && (mag_a == mag_b));
      if (both_zero)           cls.lt = 1'b0;
      else if (sgn_a != sgn_b) cls.lt = sgn_a;
      else if (!sgn_a)         cls.lt = (mag_a < mag_b);
      else                     cls.lt = (mag_a > mag_b);
   end

endmodule

// File: rtl/fcmp_lane_bank.sv
module fcmp_lane_bank
   import simd_fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int LANES = 4
) (
   input  logic [LANES*(1+EXP_W+MAN_W)-1:0] vec_a,
   input  logic [LANES*(1+EXP_W+MAN_W)-1:0] vec_b,
   input  logic                             daz,
   input  logic [PRED_W-1:0]                pred,
   output logic [LANES-1:0]                 hit,
   output logic [LANES-1:0]                 inv,
   output logic [LANES-1:0]                 den
);
   localparam int LW = 1 + EXP_W + MAN_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("fcmp_lane_bank: LANES must be at least one");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_cls_t cls;

      fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
         .op_a (vec_a[i*LW +: LW]),
         .op_b (vec_b[i*LW +: LW]),
         .daz  (daz),
         .cls  (cls)
      );

      assign hit[i] = pred_eval(pred, cls);
      assign inv[i] = pred_invalid(pred, cls);
      assign den[i] = cls.denorm;
   end

endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge
   import simd_fcmp_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  cmp_mode_e            mode,
   input  logic [VEC_W-1:0]     src_a,
   input  logic [VEC_W/32-1:0]  sp_hit,
   input  logic [VEC_W/32-1:0]  sp_inv,
   input  logic [VEC_W/32-1:0]  sp_den,
   input  logic [VEC_W/64-1:0]  dp_hit,
   input  logic [VEC_W/64-1:0]  dp_inv,
   input  logic [VEC_W/64-1:0]  dp_den,
   output logic [VEC_W-1:0]     mask_out,
   output logic                 inv_out,
   output logic                 den_out
);
   localparam int SPL = VEC_W / 32;
   localparam int DPL = VEC_W / 64;

   logic [SPL-1:0] sp_act;
   logic [DPL-1:0] dp_act;
   logic [VEC_W-1:0] sp_mask, dp_mask;

   always_comb begin
      for (int i = 0; i < SPL; i++) sp_mask[i*32 +: 32] = {32{sp_hit[i]}};
      for (int i = 0; i < DPL; i++) dp_mask[i*64 +: 64] = {64{dp_hit[i]}};

      sp_act = '0;
      dp_act = '0;
      case (mode)
         CMP_PS:  sp_act = '1;
         CMP_SS:  sp_act[0] = 1'b1;
         CMP_PD:  dp_act = '1;
         default: dp_act[0] = 1'b1;
      endcase

      case (mode)
         CMP_PS:  mask_out = sp_mask;
         CMP_PD:  mask_out = dp_mask;
         CMP_SS:  mask_out = {src_a[VEC_W-1:32], sp_mask[31:0]};
         default: mask_out = {src_a[VEC_W-1:64], dp_mask[63:0]};
      endcase

      inv_out = (|(sp_inv & sp_act)) || (|(dp_inv & dp_act));
      den_out = (|(sp_den & sp_act)) || (|(dp_den & dp_act));
   end

endmodule

// File: rtl/simd_fcmp_unit.sv
module simd_fcmp_unit
   import simd_fcmp_pkg::*;
#(
   parameter int VEC_W        = 128,
   parameter int CSR_W        = 32,
   parameter int INV_FLAG_BIT = 0,
   parameter int DEN_FLAG_BIT = 1,
   parameter int DAZ_BIT      = 6,
   parameter int INV_MASK_BIT = 7,
   parameter int DEN_MASK_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   input  logic [7:0]        imm,
   input  logic [1:0]        mode,
   input  logic [CSR_W-1:0]  csr_in,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result,
   output logic [CSR_W-1:0]  csr_out,
   output logic              xcpt_pending,
   output logic              wr_en
);
   localparam int SPL = VEC_W / 32;
   localparam int DPL = VEC_W / 64;

   if (VEC_W < 64 || (VEC_W % 64) != 0) begin : g_bad_vec
      $error("simd_fcmp_unit: VEC_W must be a positive multiple of 64");
   end
   if (INV_FLAG_BIT >= CSR_W || DEN_FLAG_BIT >= CSR_W || DAZ_BIT >= CSR_W ||
       INV_MASK_BIT >= CSR_W || DEN_MASK_BIT >= CSR_W) begin : g_bad_csr
      $error("simd_fcmp_unit: status word bit position out of range");
   end
   if (INV_FLAG_BIT == DEN_FLAG_BIT || INV_MASK_BIT == DEN_MASK_BIT) begin : g_bad_alias
      $error("simd_fcmp_unit: flag or mask positions overlap");
   end

   cmp_mode_e         mode_e;
   logic [PRED_W-1:0] pred;
   logic              daz;
   logic [SPL-1:0]    sp_hit, sp_inv, sp_den;
   logic [DPL-1:0]    dp_hit, dp_inv, dp_den;
   logic [VEC_W-1:0]  mask_nx;
   logic              inv_nx, den_nx, pend_nx;
   logic [CSR_W-1:0]  csr_nx;
   cmp_mode_e         mode_q;

   assign mode_e = cmp_mode_e'(mode);
   assign pred   = imm[PRED_W-1:0];
   assign daz    = csr_in[DAZ_BIT];

   fcmp_lane_bank #(.EXP_W(8), .MAN_W(23), .LANES(SPL)) u_sp_bank (
      .vec_a (src_a), .vec_b (src_b), .daz (daz), .pred (pred),
      .hit (sp_hit), .inv (sp_inv), .den (sp_den)
   );

   fcmp_lane_bank #(.EXP_W(11), .MAN_W(52), .LANES(DPL)) u_dp_bank (
      .vec_a (src_a), .vec_b (src_b), .daz (daz), .pred (pred),
      .hit (dp_hit), .inv (dp_inv), .den (dp_den)
   );

   fcmp_merge #(.VEC_W(VEC_W)) u_merge (
      .mode (mode_e), .src_a (src_a),
      .sp_hit (sp_hit), .sp_inv (sp_inv), .sp_den (sp_den),
      .dp_hit (dp_hit), .dp_inv (dp_inv), .dp_den (dp_den),
      .mask_out (mask_nx), .inv_out (inv_nx), .den_out (den_nx)
   );

   always_comb begin
      csr_nx = csr_in;
      csr_nx[INV_FLAG_BIT] = csr_in[INV_FLAG_BIT] | inv_nx;
      csr_nx[DEN_FLAG_BIT] = csr_in[DEN_FLAG_BIT] | den_nx;
      pend_nx = (inv_nx && !csr_in[INV_MASK_BIT]) || (den_nx && !csr_in[DEN_MASK_BIT]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         result       <= '0;
         csr_out      <= '0;
         xcpt_pending <= 1'b0;
         wr_en        <= 1'b0;
         mode_q       <= CMP_PS;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result       <= mask_nx;
            csr_out      <= csr_nx;
            xcpt_pending <= pend_nx;
            wr_en        <= !pend_nx;
            mode_q       <= mode_e;
         end else begin
            xcpt_pending <= 1'b0;
            wr_en        <= 1'b0;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R11
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R11
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_pending |-> !wr_en); // R10
   AST_WR_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> out_valid); // R10
   AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt_pending |-> ((csr_out[INV_FLAG_BIT] && !csr_out[INV_MASK_BIT]) ||
                        (csr_out[DEN_FLAG_BIT] && !csr_out[DEN_MASK_BIT]))); // R10
   AST_STICKY_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && csr_in[INV_FLAG_BIT]) |=> csr_out[INV_FLAG_BIT]); // R9
   AST_STICKY_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && csr_in[DEN_FLAG_BIT]) |=> csr_out[DEN_FLAG_BIT]); // R9
   AST_SS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == CMP_SS) |=> result[VEC_W-1:32] == $past(src_a[VEC_W-1:32])); // R6
   AST_SD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == CMP_SD) |=> result[VEC_W-1:64] == $past(src_a[VEC_W-1:64])); // R6

   for (genvar i = 0; i < SPL; i++) begin : g_chk_sp
      AST_PS_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && mode_q == CMP_PS) |->
            (result[i*32 +: 32] == '0 || result[i*32 +: 32] == '1)); // R5
   end
   for (genvar i = 0; i < DPL; i++) begin : g_chk_dp
      AST_PD_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && mode_q == CMP_PD) |->
            (result[i*64 +: 64] == '0 || result[i*64 +: 64] == '1)); // R5
   end

endmodule

// File: tb/tb_simd_fcmp_unit.sv
`timescale 1ns/1ps
module tb_simd_fcmp_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0, src_b = '0;
   logic [7:0]   imm = '0;
   logic [1:0]   mode = '0;
   logic [31:0]  csr_in = '0;
   logic         out_valid, xcpt_pending, wr_en;
   logic [127:0] result;
   logic [31:0]  csr_out;

   int n_checks = 0;
   int n_fail   = 0;

   localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000;
   localparam logic [31:0] SM1 = 32'hBF800000, SM2 = 32'hC0000000;
   localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001;
   localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
   localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;
   localparam logic [31:0] ONES = 32'hFFFFFFFF;

   // {unordered, equal, less, greater} per predicate, from the requirement text
   logic [3:0] row [8];

   simd_fcmp_unit dut (
      .clk, .rst_n, .in_valid, .src_a, .src_b, .imm, .mode, .csr_in,
      .out_valid, .result, .csr_out, .xcpt_pending, .wr_en
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [7:0] i,
                        input logic [1:0] m, input logic [31:0] c);
      @(negedge clk);
      src_a = a; src_b = b; imm = i; mode = m; csr_in = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R11", "out_valid at reset", {127'd0, out_valid}, 128'd0);
      chk("R11", "result at reset", result, 128'd0);
      chk("R11", "wr_en/xcpt at reset", {126'd0, wr_en, xcpt_pending}, 128'd0);
   endtask

   task automatic t_predicates;  // R1: lanes lt, gt, eq, unordered
      for (int k = 0; k < 8; k++) begin
         logic sig;
         sig = (k == 1) || (k == 2) || (k == 5) || (k == 6);
         issue({SQN, S1, S2, S1}, {S1, S1, S1, S2}, 8'(k), 2'd0, 32'h180);
         chk("R1", $sformatf("pred %0d lanes", k), result,
             {{32{row[k][3]}}, {32{row[k][2]}}, {32{row[k][0]}}, {32{row[k][1]}}});
         chk("R4", $sformatf("pred %0d qnan invalid", k), {96'd0, csr_out}, {96'd0, 32'h180 | {31'd0, sig}});
      end
   endtask

   task automatic t_imm_upper;
      issue({SQN, S1, S2, S1}, {S1, S1, S1, S2}, 8'hF9, 2'd0, 32'h180);
      chk("R2", "imm F9 acts as pred 1", result, {96'd0, ONES});
      chk("R2", "imm F9 flags", {96'd0, csr_out}, {96'd0, 32'h181});
      issue({SQN, S1, S2, S1}, {S1, S1, S1, S2}, 8'h0B, 2'd0, 32'h100);
      chk("R2", "imm 0B acts as pred 3", result, {ONES, 96'd0});
      chk("R2", "imm 0B no exception", {126'd0, xcpt_pending, wr_en}, 128'd1);
   endtask

   task automatic t_snan;
      issue({S1, S1, S1, SSN}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h100);
      chk("R3", "snan lane unordered", result, {ONES, ONES, ONES, 32'd0});
      chk("R3", "snan invalid flag", {96'd0, csr_out}, {96'd0, 32'h101});
      chk("R10", "unmasked invalid pending", {126'd0, xcpt_pending, wr_en}, 128'd2);
      issue({S1, S1, S1, S1}, {S1, S1, S1, SSN}, 8'd3, 2'd0, 32'h180);
      chk("R3", "snan in src_b pred 3", result, {96'd0, ONES});
      chk("R10", "masked invalid no pending", {126'd0, xcpt_pending, wr_en}, 128'd1);
   endtask

   task automatic t_qnan;
      issue({S1, S1, S1, SQN}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h100);
      chk("R4", "qnan quiet pred", result, {ONES, ONES, ONES, 32'd0});
      chk("R4", "qnan quiet no flag", {95'd0, csr_out, xcpt_pending}, {95'd0, 32'h100, 1'b0});
      issue({S1, S1, S1, SQN}, {S1, S1, S1, S1}, 8'd5, 2'd0, 32'h100);
      chk("R4", "qnan pred 5", result, {ONES, ONES, ONES, ONES});
      chk("R4", "qnan pred 5 signals", {95'd0, csr_out, xcpt_pending}, {95'd0, 32'h101, 1'b1});
   endtask

   task automatic t_signed;
      issue({SM1, SM2, SM1, 32'h00000000}, {SM2, SM1, S1, 32'h80000000}, 8'd2, 2'd0, 32'h180);
      chk("R7", "le with zeros and negatives", result, {32'd0, ONES, ONES, ONES});
      issue({SM1, SM2, SM1, 32'h00000000}, {SM2, SM1, S1, 32'h80000000}, 8'd0, 2'd0, 32'h180);
      chk("R7", "+0 equals -0", result, {96'd0, ONES});
   endtask

   task automatic t_denorm;
      issue({S1, S1, 32'h80000001, 32'h00000001}, {S1, S1, 32'h0, 32'h0}, 8'd0, 2'd0, 32'h080);
      chk("R8", "denormal compared as value", result, {ONES, ONES, 32'd0, 32'd0});
      chk("R8", "denormal flag", {96'd0, csr_out}, {96'd0, 32'h082});
      chk("R10", "unmasked denormal pending", {126'd0, xcpt_pending, wr_en}, 128'd2);
      issue({S1, S1, 32'h80000001, 32'h00000001}, {S1, S1, 32'h0, 32'h0}, 8'd0, 2'd0, 32'h0C0);
      chk("R8", "DAZ treats denormal as zero", result, {ONES, ONES, ONES, ONES});
      chk("R8", "DAZ raises no flag", {95'd0, csr_out, xcpt_pending}, {95'd0, 32'h0C0, 1'b0});
   endtask

   task automatic t_sticky;
      issue({S1, S1, S1, S1}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h6183);
      chk("R9", "status bits pass through", {96'd0, csr_out}, {96'd0, 32'h6183});
      issue({S1, S1, S1, S1}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h0001);
      chk("R9", "old flag kept", {96'd0, csr_out}, {96'd0, 32'h0001});
      chk("R10", "old flag raises no pending", {126'd0, xcpt_pending, wr_en}, 128'd1);
   endtask

   task automatic t_packed_double;
      issue({D2, D1}, {D1, D2}, 8'd1, 2'd1, 32'h180);
      chk("R5", "pd less-than", result, {64'd0, {2{ONES}}});
      issue({DQN, D1}, {D1, D1}, 8'd3, 2'd1, 32'h180);
      chk("R5", "pd unordered hi", result, {{2{ONES}}, 64'd0});
   endtask

   task automatic t_scalar;
      issue({96'hDEADBEEF_01234567_89ABCDEF, S1}, {SSN, SSN, SSN, S2}, 8'd1, 2'd2, 32'h100);
      chk("R6", "ss result and upper copy", result, {96'hDEADBEEF_01234567_89ABCDEF, ONES});
      chk("R12", "ss ignores upper snan", {95'd0, csr_out, xcpt_pending}, {95'd0, 32'h100, 1'b0});
      issue({64'hCAFEF00D_12345678, D1}, {DSN, D2}, 8'd6, 2'd3, 32'h100);
      chk("R6", "sd result and upper copy", result, {64'hCAFEF00D_12345678, 64'd0});
      chk("R12", "sd ignores upper snan", {95'd0, csr_out, xcpt_pending}, {95'd0, 32'h100, 1'b0});
   endtask

   task automatic t_lane_or;
      issue({SSN, S1, S1, S1}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h180);
      chk("R12", "snan in top lane flags", {96'd0, csr_out}, {96'd0, 32'h181});
      chk("R12", "top lane zero", result, {32'd0, ONES, ONES, ONES});
      issue({DSN, D1}, {D1, D1}, 8'd0, 2'd1, 32'h180);
      chk("R12", "pd hi snan flags", {96'd0, csr_out}, {96'd0, 32'h181});
   endtask

   task automatic t_latency;
      issue({S1, S1, S1, S1}, {S1, S1, S1, S1}, 8'd0, 2'd0, 32'h180);
      chk("R11", "valid one cycle later", {127'd0, out_valid}, 128'd1);
      @(negedge clk);
      chk("R11", "valid drops", {125'd0, out_valid, wr_en, xcpt_pending}, 128'd0);
   endtask

   initial begin
      row[0] = 4'b0100; row[1] = 4'b0010; row[2] = 4'b0110; row[3] = 4'b1000;
      row[4] = 4'b1011; row[5] = 4'b1101; row[6] = 4'b1001; row[7] = 4'b0111;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_predicates();
      t_imm_upper();
      t_snan();
      t_qnan();
      t_signed();
      t_denorm();
      t_sticky();
      t_packed_double();
      t_scalar();
      t_lane_or();
      t_latency();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule